// File: doc/BRIEF.md
# Dual-Setpoint Voltage Ramp Generator

This block produces the 7-bit reference code that sets a buck converter's output voltage. The voltage is 600 mV plus 6.25 mV per code step, so code 0 is 600 mV and code 127 is 1393.75 mV. Two setpoint codes are held in registers elsewhere. A select pin and a gating bit choose which one is the target. The block then walks its reference code toward that target one LSB at a time. The pace comes from a credit accumulator fed by a once-per-microsecond tick, and rising and falling moves have separate programmable rates.

Each setpoint has its own bit that chooses forced PWM or automatic mode, and the block drives the converter's mode select from it. A transition-mode bit forces PWM for the whole of a paced downward move. A downward move is paced only when PWM is forced, either by the active setpoint's bit or by the transition-mode bit. Otherwise the output can fall only as fast as the load drains it, and the reference code jumps straight to the target. A power-good mask tells the power-good comparator to hold its state while a ramp is in progress, unless tracking during transitions is enabled.

The controller has four states:
- `RS_INIT`: the first cycle after reset. It loads the target directly and moves to `RS_HOLD`.
- `RS_HOLD`: idle at the target.
  - If the target is higher, it moves to `RS_RISE`.
  - If the target is lower and the move is paced, it moves to `RS_FALL`.
  - If the target is lower and the move is unpaced, it loads the target and stays in `RS_HOLD`.
- `RS_RISE` and `RS_FALL`: stepping. On every cycle they compare the reference with the target again.
  - If the two are equal, they return to `RS_HOLD`.
  - If the direction has reversed, they switch between `RS_RISE` and `RS_FALL`.
  - An unpaced downward target jumps and returns to `RS_HOLD`.

Top module: `dvs_ramp_gen`

## Requirements
- R1: When `pin_sel_en` is 1, `vsel_pin`=1 makes `code_hi` the target and `vsel_pin`=0 makes `code_lo` the target. When `pin_sel_en` is 0, `code_hi` is the target whatever the pin does. The active PWM bit follows the same choice: `fpwm_hi` or `fpwm_lo`.
- R2: While reset is held, `ref_code` is 0 and `ramp_busy`, `pg_freeze` are 0. The first clock edge after reset is released loads the selected target directly, with no ramp.
- R3: An upward move steps one LSB at a time. `up_rate_sel` maps to mV/µs as follows: 000=64, 001=16, 010=32, 110=32, 011=8, 111=8, 100=4, 101=4. After K ticks in a ramp, the code is start + floor(K·4·rate/25), capped at the target.
- R4: A paced downward move steps one LSB at a time. `dn_rate_sel` maps to mV/µs as follows: 00=32, 01=4, 10=8, 11=16. After K ticks the code is start − floor(K·4·rate/25), floored at the target.
- R5: A downward move is paced only when the active PWM bit or `dvs_fpwm` is 1. Otherwise `ref_code` equals the target one edge after the target changes, and `ramp_busy` stays 0.
- R6: `fpwm_mode` equals the active setpoint's PWM bit. During a paced downward ramp it is also 1 whenever `dvs_fpwm` is 1.
- R7: `pg_freeze` is 1 exactly while a ramp is in progress and `pg_track` is 0.
- R8: A target change in the middle of a ramp redirects the ramp from the present code, without a jump in `ref_code`.
- R9: `ramp_busy` is 1 while stepping and drops once the code reaches the target. The code then stays at the target, and no stepping credit carries over into the next ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| vsel_pin | input | 1 | Setpoint select pin |
| pin_sel_en | input | 1 | 1: the pin chooses the setpoint; 0: `code_hi` is always used |
| code_hi | input | 7 | Setpoint code chosen when the pin is high |
| code_lo | input | 7 | Setpoint code chosen when the pin is low |
| fpwm_hi | input | 1 | Forced-PWM bit for `code_hi` |
| fpwm_lo | input | 1 | Forced-PWM bit for `code_lo` |
| dvs_fpwm | input | 1 | Forces PWM and pacing during downward moves |
| pg_track | input | 1 | 1: power-good may follow the output during ramps |
| up_rate_sel | input | 3 | Rising slew code |
| dn_rate_sel | input | 2 | Falling slew code |
| ref_code | output | 7 | Reference voltage code |
| fpwm_mode | output | 1 | 1: forced PWM, 0: automatic |
| ramp_busy | output | 1 | Ramp in progress |
| pg_freeze | output | 1 | Hold power-good state |

## Verification
Directed moves use aliased up-rate codes (010 and 110), the fastest and the slowest rate, a gated select that ignores the pin, an unpaced fall, and a rise reversed halfway into a paced fall. Between them these separate decode errors, wrong setpoint choice, a missing jump and a jump on redirect. Random moves with a fixed seed vary the targets, the select bits, the PWM and tracking bits, the rates and the tick count. A bench model predicts the mid-ramp code, busy, mode and mask, which exposes off-by-one pacing, wrong direction pacing and mode/mask errors. Each move is then run to the end to confirm that the ramp settles at the target.

// File: rtl/dvs_pkg.sv
package dvs_pkg;

    typedef enum logic [1:0] {
        RS_INIT,
        RS_HOLD,
        RS_RISE,
        RS_FALL
    } ramp_state_t;

    // Slew rates expressed in quarter-millivolts per microsecond tick.
    function automatic logic [8:0] up_rate_q(input logic [2:0] sel);
        logic [8:0] r;
        unique case (sel)
            3'b000:          r = 9'd256;
            3'b001:          r = 9'd64;
            3'b010, 3'b110:  r = 9'd128;
            3'b011, 3'b111:  r = 9'd32;
            default:         r = 9'd16;
        endcase
        return r;
    endfunction

    function automatic logic [8:0] dn_rate_q(input logic [1:0] sel);
        logic [8:0] r;
        unique case (sel)
            2'b00:   r = 9'd128;
            2'b01:   r = 9'd16;
            2'b10:   r = 9'd32;
            default: r = 9'd64;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dvs_target_sel.sv
module dvs_target_sel #(
    parameter int CODE_W = 7
) (
    input  logic              vsel_pin,
    input  logic              pin_sel_en,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [CODE_W-1:0] code_lo,
    input  logic              fpwm_hi,
    input  logic              fpwm_lo,
    output logic [CODE_W-1:0] tgt_code,
    output logic              act_fpwm
);

    logic use_hi;

    always_comb begin
        use_hi   = !pin_sel_en || vsel_pin;
        tgt_code = use_hi ? code_hi : code_lo;
        act_fpwm = use_hi ? fpwm_hi : fpwm_lo;
    end

endmodule

// File: rtl/dvs_step_pacer.sv
module dvs_step_pacer
    import dvs_pkg::*;
#(
    parameter int CRED_W = 10,
    parameter int STEP_Q = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       clear,
    input  logic       dir_up,
    input  logic [2:0] up_sel,
    input  logic [1:0] dn_sel,
    input  logic       consume,
    output logic       can_step
);

    localparam int SUM_W = CRED_W + 1;
    localparam logic [SUM_W-1:0] CRED_MAX = SUM_W'((1 << CRED_W) - 1);

    logic [CRED_W-1:0] credit_q;
    logic [CRED_W-1:0] credit_d;
    logic [8:0]        add_q;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        add_q = dir_up ? up_rate_q(up_sel) : dn_rate_q(dn_sel);
        sum   = {1'b0, credit_q};
        if (tick) begin
            sum = sum + {{(SUM_W-9){1'b0}}, add_q};
        end
        if (consume) begin
            sum = sum - SUM_W'(STEP_Q);
        end
        if (clear) begin
            credit_d = '0;
        end else if (sum > CRED_MAX) begin
            credit_d = CRED_MAX[CRED_W-1:0];
        end else begin
            credit_d = sum[CRED_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else begin
            credit_q <= credit_d;
        end
    end

    assign can_step = credit_q >= CRED_W'(STEP_Q);

    // R9: a cleared accumulator grants no step on the following cycle
    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !can_step);

endmodule

// File: rtl/dvs_ramp_fsm.sv
module dvs_ramp_fsm
    import dvs_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] tgt_code,
    input  logic              act_fpwm,
    input  logic              dvs_fpwm,
    input  logic              pg_track,
    input  logic              can_step,
    output logic [CODE_W-1:0] ref_code,
    output logic              dir_up,
    output logic              pace_clear,
    output logic              step_take,
    output logic              fpwm_mode,
    output logic              ramp_busy,
    output logic              pg_freeze
);

    ramp_state_t       state_q, state_d;
    logic [CODE_W-1:0] ref_q, ref_d;
    logic              paced;

    assign paced = act_fpwm || dvs_fpwm;

    always_comb begin
        state_d   = state_q;
        ref_d     = ref_q;
        step_take = 1'b0;
        unique case (state_q)
            RS_INIT: begin
                ref_d   = tgt_code;
                state_d = RS_HOLD;
            end
            RS_HOLD, RS_RISE, RS_FALL: begin
                if (tgt_code == ref_q) begin
                    state_d = RS_HOLD;
                end else if (tgt_code > ref_q) begin
                    state_d = RS_RISE;
                    if (state_q == RS_RISE && can_step) begin
                        ref_d     = ref_q + 1'b1;
                        step_take = 1'b1;
                    end
                end else if (!paced) begin
                    ref_d   = tgt_code;
                    state_d = RS_HOLD;
                end else begin
                    state_d = RS_FALL;
                    if (state_q == RS_FALL && can_step) begin
                        ref_d     = ref_q - 1'b1;
                        step_take = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_INIT;
            ref_q   <= '0;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_d;
        end
    end

    always_comb begin
        ref_code   = ref_q;
        dir_up     = (state_q == RS_RISE);
        ramp_busy  = (state_q == RS_RISE) || (state_q == RS_FALL);
        pace_clear = (state_q == RS_INIT) || (state_q == RS_HOLD) || (state_d != state_q);
        fpwm_mode  = act_fpwm || ((state_q == RS_FALL) && dvs_fpwm);
        pg_freeze  = ramp_busy && !pg_track;
    end

    // R3 / R8: the code never rises by more than one LSB per cycle
    assert_one_lsb_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RS_INIT) |=> ({1'b0, ref_q} <= {1'b0, $past(ref_q)} + 8'd1));

    // R4: a paced move never drops by more than one LSB per cycle
    assert_paced_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RS_INIT && paced) |=> ({1'b0, ref_q} + 8'd1 >= {1'b0, $past(ref_q)}));

    // R5: an unpaced fall lands on the target in one edge and is not busy
    assert_unpaced_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != RS_INIT && !paced && tgt_code < ref_q) |=> (ref_q == $past(tgt_code) && !ramp_busy));

    // R9: once settled with an unchanged target, the code holds
    assert_hold_keeps_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HOLD && tgt_code == ref_q) |=> $stable(ref_q));

endmodule

// File: rtl/dvs_ramp_gen.sv
module dvs_ramp_gen #(
    parameter int CODE_W = 7,
    parameter int CRED_W = 10,
    parameter int STEP_Q = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              vsel_pin,
    input  logic              pin_sel_en,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [CODE_W-1:0] code_lo,
    input  logic              fpwm_hi,
    input  logic              fpwm_lo,
    input  logic              dvs_fpwm,
    input  logic              pg_track,
    input  logic [2:0]        up_rate_sel,
    input  logic [1:0]        dn_rate_sel,
    output logic [CODE_W-1:0] ref_code,
    output logic              fpwm_mode,
    output logic              ramp_busy,
    output logic              pg_freeze
);

    logic [CODE_W-1:0] tgt_code;
    logic              act_fpwm;
    logic              can_step;
    logic              dir_up;
    logic              pace_clear;
    logic              step_take;

    dvs_target_sel #(.CODE_W(CODE_W)) sel_i (
        .vsel_pin   (vsel_pin),
        .pin_sel_en (pin_sel_en),
        .code_hi    (code_hi),
        .code_lo    (code_lo),
        .fpwm_hi    (fpwm_hi),
        .fpwm_lo    (fpwm_lo),
        .tgt_code   (tgt_code),
        .act_fpwm   (act_fpwm)
    );

    dvs_step_pacer #(.CRED_W(CRED_W), .STEP_Q(STEP_Q)) pace_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (us_tick),
        .clear    (pace_clear),
        .dir_up   (dir_up),
        .up_sel   (up_rate_sel),
        .dn_sel   (dn_rate_sel),
        .consume  (step_take),
        .can_step (can_step)
    );

    dvs_ramp_fsm #(.CODE_W(CODE_W)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tgt_code   (tgt_code),
        .act_fpwm   (act_fpwm),
        .dvs_fpwm   (dvs_fpwm),
        .pg_track   (pg_track),
        .can_step   (can_step),
        .ref_code   (ref_code),
        .dir_up     (dir_up),
        .pace_clear (pace_clear),
        .step_take  (step_take),
        .fpwm_mode  (fpwm_mode),
        .ramp_busy  (ramp_busy),
        .pg_freeze  (pg_freeze)
    );

    // R3: without stepping credit, a ramp cannot raise the code
    assert_step_needs_credit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_busy && !can_step) |=> (ref_code <= $past(ref_code)));

endmodule

// File: tb/dvs_ramp_gen_tb_top.sv
`timescale 1ns/1ps
module dvs_ramp_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic       vsel_pin = 1'b0;
    logic       pin_sel_en = 1'b1;
    logic [6:0] code_hi = 7'h50;
    logic [6:0] code_lo = 7'h10;
    logic       fpwm_hi = 1'b0;
    logic       fpwm_lo = 1'b0;
    logic       dvs_fpwm = 1'b0;
    logic       pg_track = 1'b0;
    logic [2:0] up_rate_sel = 3'b000;
    logic [1:0] dn_rate_sel = 2'b00;
    logic [6:0] ref_code;
    logic       fpwm_mode, ramp_busy, pg_freeze;

    int checks = 0;
    int fails = 0;
    int cur = 0;

    always #2.5 clk = ~clk;

    dvs_ramp_gen dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .vsel_pin(vsel_pin),
        .pin_sel_en(pin_sel_en), .code_hi(code_hi), .code_lo(code_lo),
        .fpwm_hi(fpwm_hi), .fpwm_lo(fpwm_lo), .dvs_fpwm(dvs_fpwm),
        .pg_track(pg_track), .up_rate_sel(up_rate_sel), .dn_rate_sel(dn_rate_sel),
        .ref_code(ref_code), .fpwm_mode(fpwm_mode), .ramp_busy(ramp_busy),
        .pg_freeze(pg_freeze)
    );

    function automatic int up_mv(input logic [2:0] s);
        case (s)
            3'b000: return 64;
            3'b001: return 16;
            3'b010, 3'b110: return 32;
            3'b011, 3'b111: return 8;
            default: return 4;
        endcase
    endfunction

    function automatic int dn_mv(input logic [1:0] s);
        case (s)
            2'b00: return 32;
            2'b01: return 4;
            2'b10: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic int sel_target();
        return (!pin_sel_en || vsel_pin) ? int'(code_hi) : int'(code_lo);
    endfunction

    function automatic int sel_fpwm();
        return (!pin_sel_en || vsel_pin) ? int'(fpwm_hi) : int'(fpwm_lo);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            cyc(15);
        end
    endtask

    // Apply the present inputs as a move, check mid-ramp after k ticks, then settle.
    task automatic run_move(input int k);
        int t, a, r, steps, e, need;
        bit up, busy_e;
        string tag;
        t = sel_target();
        a = sel_fpwm();
        cyc(2);
        if (t == cur || (t < cur && !(a != 0 || dvs_fpwm))) begin
            chk("R5 code", int'(ref_code), t);
            chk("R5 busy", int'(ramp_busy), 0);
            chk("R6 mode", int'(fpwm_mode), a);
            cur = t;
            return;
        end
        up  = (t > cur);
        r   = up ? up_mv(up_rate_sel) : dn_mv(dn_rate_sel);
        tag = up ? "R3" : "R4";
        ticks(k);
        steps = (k * 4 * r) / 25;
        if (up) e = (cur + steps > t) ? t : cur + steps;
        else    e = (cur - steps < t) ? t : cur - steps;
        busy_e = (e != t);
        chk({tag, " code"}, int'(ref_code), e);
        chk({tag, " busy"}, int'(ramp_busy), int'(busy_e));
        chk("R6 mode", int'(fpwm_mode), (a != 0 || (busy_e && !up && dvs_fpwm)) ? 1 : 0);
        chk("R7 mask", int'(pg_freeze), (busy_e && !pg_track) ? 1 : 0);
        need = ((up ? t - e : e - t) * 25 + 4 * r - 1) / (4 * r);
        ticks(need + 1);
        chk("R9 settle code", int'(ref_code), t);
        chk("R9 settle busy", int'(ramp_busy), 0);
        cur = t;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cyc(3);
        chk("R2 reset code", int'(ref_code), 0);
        chk("R2 reset busy", int'(ramp_busy), 0);
        chk("R2 reset mask", int'(pg_freeze), 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R2 load code", int'(ref_code), 16);
        chk("R2 load busy", int'(ramp_busy), 0);
        cur = 16;

        // R1: gating off ignores the pin, code_hi at fastest rate; R6 forced PWM
        pin_sel_en = 1'b0; vsel_pin = 1'b0; fpwm_hi = 1'b1; up_rate_sel = 3'b000;
        run_move(1);
        chk("R1 gated target", int'(ref_code), 8'h50);

        // R5: unpaced fall to code_lo jumps
        pin_sel_en = 1'b1; fpwm_lo = 1'b0; dvs_fpwm = 1'b0;
        run_move(1);
        chk("R1 pin low target", int'(ref_code), 8'h10);

        // R3: aliased up codes 110 and 010 give the same pace
        vsel_pin = 1'b1; fpwm_hi = 1'b0; up_rate_sel = 3'b110;
        run_move(3);
        code_lo = 7'h20; vsel_pin = 1'b0; run_move(1);
        vsel_pin = 1'b1; up_rate_sel = 3'b010;
        run_move(3);

        // R8 redirect, R6 forced PWM on paced fall, R7 tracking
        code_lo = 7'h10; vsel_pin = 1'b0; run_move(1);
        vsel_pin = 1'b1; up_rate_sel = 3'b100; pg_track = 1'b1; dvs_fpwm = 1'b1;
        cyc(2);
        ticks(10);
        chk("R3 slow rise", int'(ref_code), 8'h16);
        chk("R7 tracking mask", int'(pg_freeze), 0);
        code_hi = 7'h13; dn_rate_sel = 2'b01;
        cyc(2);
        chk("R8 no jump", int'(ref_code), 8'h16);
        chk("R8 still busy", int'(ramp_busy), 1);
        chk("R6 fall forced", int'(fpwm_mode), 1);
        ticks(4);
        chk("R4 slow fall", int'(ref_code), 8'h14);
        ticks(1);
        chk("R8 arrive", int'(ref_code), 8'h13);
        chk("R9 idle", int'(ramp_busy), 0);
        chk("R6 after fall", int'(fpwm_mode), 0);
        cur = 8'h13;
        pg_track = 1'b0;

        for (int n = 0; n < 25; n++) begin
            code_hi     = 7'($urandom);
            code_lo     = 7'($urandom);
            vsel_pin    = 1'($urandom);
            pin_sel_en  = 1'($urandom);
            fpwm_hi     = 1'($urandom);
            fpwm_lo     = 1'($urandom);
            dvs_fpwm    = 1'($urandom);
            pg_track    = 1'($urandom);
            up_rate_sel = 3'($urandom);
            dn_rate_sel = 2'($urandom);
            run_move(1 + int'($urandom % 6));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule